// File: doc/BRIEF.md
# Vectored Nested Interrupt Controller

This block collects 32 interrupt request lines and presents them to a processor that has one normal interrupt input and one fast interrupt input. Each line can be set to level or edge triggering, with either polarity. Each line has an enable bit, a priority from 0 to 7 and a 32-bit vector of its own. Line 0 feeds the fast output directly and never takes part in priority arbitration. Lines 1 to 31 compete for the normal output. Software can also steer any of lines 1 to 31 to the fast output.

The processor reads the interrupt vector word to learn which handler to run. That read returns the vector of the best pending line. It also pushes that line's priority onto an eight-entry stack and clears its edge latch. A later line raises the normal output only if its priority is strictly above the top of the stack, which is how nesting works. An end-of-service write pops the stack. A protect mode makes vector reads free of side effects, so a debugger can inspect them; in that mode a write to the vector word does the stacking instead. A global mask silences both interrupt outputs, but a separate wake output keeps showing any enabled pending line.

Register map at word address `addr_i`, for 32 lines:
- 0x00–0x1F: line configuration.
- 0x20–0x3F: line vectors.
- 0x40: interrupt vector.
- 0x41: fast vector.
- 0x42: enable set (reads back the enable mask).
- 0x43: enable clear.
- 0x44: force set (reads back the force mask).
- 0x45: force clear.
- 0x46: end of service.
- 0x47: control, with bit 0 the global mask and bit 1 protect mode.
- 0x48: spurious vector.
- 0x49: raw pending bits (read only).
- 0x4A: edge-latch clear (write 1s).

Top module: `vnic_top`

## Requirements
- R1: After reset, `irq_o`, `fiq_o` and `wake_o` are low, and the enable, force and control words read 0.
- R2: In level mode (configuration bit 3 = 0), a line is pending while its input equals the active level: high when bit 4 = 0, low when bit 4 = 1. Both outputs follow the input in the same cycle.
- R3: In edge mode (configuration bit 3 = 1), a rising edge (bit 4 = 0) or a falling edge (bit 4 = 1) sets a latch. The latch stays set after the input returns, and an input level alone never sets it.
- R4: A line whose enable bit is clear never affects `irq_o`, `fiq_o` or `wake_o`. Enable set and enable clear writes change only the bits written as 1.
- R5: Among pending, enabled, unforced lines 1–31, the winner is the one with the highest priority (configuration bits 2:0); on a tie, the lowest line number wins. Reading 0x40 returns the winner's vector.
- R6: Outside protect mode, a read of 0x40 with a winner pushes the winner's priority and clears its edge latch. `irq_o` then stays low until a line of strictly higher priority is pending.
- R7: While a priority is being served, a pending line of equal or lower priority leaves `irq_o` low, and a line of higher priority raises it.
- R8: A write to 0x46 pops the stack, so lines that were blocked by the popped level can raise `irq_o` again.
- R9: A read of 0x40 with no eligible line returns the spurious vector (0x48) and leaves the stack unchanged.
- R10: Line 0 drives `fiq_o` and never `irq_o`. A read of 0x41 returns line 0's vector and clears line 0's edge latch.
- R11: A line set in the force mask drives `fiq_o` instead of `irq_o`. Vector reads never clear its latch; only a write to 0x4A clears it.
- R12: With global mask set, `irq_o` and `fiq_o` are low while `wake_o` still shows any enabled pending line.
- R13: In protect mode, a read of 0x40 returns the same vector without stacking or clearing. A write to 0x40 performs the stacking and clearing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 32 | Interrupt request lines, already synchronous |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe, used for read side effects |
| addr_i | input | 7 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |
| wake_o | output | 1 | Any enabled line pending, ignoring mask and priority |

## Verification
Level-mode lines, the arbitration result and `rdata_o` are combinational, so they are due in the same cycle as the input or address that causes them. An edge latch sets on the first clock edge after the input transition. A register write, and the stack push, pop or latch clear caused by a read or write, is visible after the clock edge that ends that access. The bench drives every input just after a falling edge and samples outputs one time unit later. Effects of an access are checked only after the following falling edge, which places each sample after the one register stage on its path.

// File: rtl/vnic_pkg.sv
package vnic_pkg;
  localparam int unsigned PRIO_W = 3;
  localparam int unsigned CFG_W  = PRIO_W + 2;

  // word offsets above the per-line config and vector blocks
  localparam int unsigned OFS_IVEC    = 0;
  localparam int unsigned OFS_FVEC    = 1;
  localparam int unsigned OFS_EN_SET  = 2;
  localparam int unsigned OFS_EN_CLR  = 3;
  localparam int unsigned OFS_FRC_SET = 4;
  localparam int unsigned OFS_FRC_CLR = 5;
  localparam int unsigned OFS_EOI     = 6;
  localparam int unsigned OFS_CTRL    = 7;
  localparam int unsigned OFS_SPUR    = 8;
  localparam int unsigned OFS_PEND    = 9;
  localparam int unsigned OFS_ECLR    = 10;

  typedef struct packed {
    logic              inv;
    logic              edge_md;
    logic [PRIO_W-1:0] prio;
  } src_cfg_t;
endpackage

// File: rtl/vnic_src_cell.sv
module vnic_src_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic src_i,
  input  logic edge_i,
  input  logic inv_i,
  input  logic clr_i,
  output logic pend_o
);
  logic prev_q, latch_q, hit;

  // edge detect on the raw line so a polarity change cannot fake an edge
  assign hit = inv_i ? (prev_q & ~src_i) : (src_i & ~prev_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      prev_q <= src_i;
      if (edge_i && hit)         latch_q <= 1'b1;
      else if (clr_i || !edge_i) latch_q <= 1'b0;
    end
  end

  assign pend_o = edge_i ? latch_q : (src_i ^ inv_i);
endmodule

// File: rtl/vnic_arbiter.sv
module vnic_arbiter #(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned PRIO_W  = 3,
  parameter int unsigned IDX_W   = 5
) (
  input  logic [NUM_SRC-1:0]        cand_i,
  input  logic [NUM_SRC*PRIO_W-1:0] prio_i,
  output logic                      valid_o,
  output logic [IDX_W-1:0]          idx_o,
  output logic [PRIO_W-1:0]         prio_o
);
  always_comb begin
    logic              found;
    logic [IDX_W-1:0]  best_idx;
    logic [PRIO_W-1:0] best_prio;
    found     = 1'b0;
    best_idx  = '0;
    best_prio = '0;
    // strict compare keeps the lowest index on a tie
    for (int i = 0; i < NUM_SRC; i++) begin
      if (cand_i[i] && (!found || prio_i[i*PRIO_W +: PRIO_W] > best_prio)) begin
        found     = 1'b1;
        best_idx  = IDX_W'(i);
        best_prio = prio_i[i*PRIO_W +: PRIO_W];
      end
    end
    valid_o = found;
    idx_o   = best_idx;
    prio_o  = best_prio;
  end
endmodule

// File: rtl/vnic_prio_stack.sv
module vnic_prio_stack #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned PRIO_W = 3,
  parameter int unsigned CNT_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic [PRIO_W-1:0] prio_i,
  output logic [PRIO_W-1:0] top_o,
  output logic [CNT_W-1:0]  cnt_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [PRIO_W-1:0] mem_q [DEPTH];
  logic [CNT_W-1:0]  cnt_q;
  logic              can_push;

  assign can_push = push_i && (cnt_q < CNT_W'(DEPTH));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (can_push)              cnt_q <= cnt_q + 1'b1;
    else if (pop_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (can_push) mem_q[PTR_W'(cnt_q)] <= prio_i;
  end

  assign top_o = (cnt_q == '0) ? '0 : mem_q[PTR_W'(cnt_q - 1'b1)];
  assign cnt_o = cnt_q;
endmodule

// File: rtl/vnic_top.sv
module vnic_top
  import vnic_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned DEPTH   = 8,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 7
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               wr_en_i,
  input  logic               rd_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               irq_o,
  output logic               fiq_o,
  output logic               wake_o
);
  localparam int unsigned IDX_W     = $clog2(NUM_SRC);
  localparam int unsigned CNT_W     = $clog2(DEPTH + 1);
  localparam int unsigned CTRL_BASE = 2 * NUM_SRC;
  localparam logic [ADDR_W-1:0] A_IVEC    = ADDR_W'(CTRL_BASE + OFS_IVEC);
  localparam logic [ADDR_W-1:0] A_FVEC    = ADDR_W'(CTRL_BASE + OFS_FVEC);
  localparam logic [ADDR_W-1:0] A_EN_SET  = ADDR_W'(CTRL_BASE + OFS_EN_SET);
  localparam logic [ADDR_W-1:0] A_EN_CLR  = ADDR_W'(CTRL_BASE + OFS_EN_CLR);
  localparam logic [ADDR_W-1:0] A_FRC_SET = ADDR_W'(CTRL_BASE + OFS_FRC_SET);
  localparam logic [ADDR_W-1:0] A_FRC_CLR = ADDR_W'(CTRL_BASE + OFS_FRC_CLR);
  localparam logic [ADDR_W-1:0] A_EOI     = ADDR_W'(CTRL_BASE + OFS_EOI);
  localparam logic [ADDR_W-1:0] A_CTRL    = ADDR_W'(CTRL_BASE + OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_SPUR    = ADDR_W'(CTRL_BASE + OFS_SPUR);
  localparam logic [ADDR_W-1:0] A_PEND    = ADDR_W'(CTRL_BASE + OFS_PEND);
  localparam logic [ADDR_W-1:0] A_ECLR    = ADDR_W'(CTRL_BASE + OFS_ECLR);
  localparam logic [NUM_SRC-1:0] NORM_MASK = ~NUM_SRC'(1);

  src_cfg_t                  cfg_q [NUM_SRC];
  logic [DATA_W-1:0]         vec_q [NUM_SRC];
  logic [NUM_SRC-1:0]        en_q, frc_q, pend, en_pend, cand, clr;
  logic                      gmask_q, prot_q;
  logic [DATA_W-1:0]         spur_q;
  logic [NUM_SRC*PRIO_W-1:0] prio_flat;
  logic                      in_cfg, in_vec, hit_ivec, eligible, push, pop;
  logic [IDX_W-1:0]          sel_idx, win_idx;
  logic                      win_vld;
  logic [PRIO_W-1:0]         win_prio, top_prio;
  logic [CNT_W-1:0]          stk_cnt;

  assign in_cfg  = addr_i < ADDR_W'(NUM_SRC);
  assign in_vec  = !in_cfg && (addr_i < ADDR_W'(2 * NUM_SRC));
  assign sel_idx = in_cfg ? addr_i[IDX_W-1:0] : IDX_W'(addr_i - ADDR_W'(NUM_SRC));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_SRC; i++) begin
        cfg_q[i] <= '0;
        vec_q[i] <= '0;
      end
      en_q    <= '0;
      frc_q   <= '0;
      gmask_q <= 1'b0;
      prot_q  <= 1'b0;
      spur_q  <= '0;
    end else if (wr_en_i) begin
      if (in_cfg)      cfg_q[sel_idx] <= src_cfg_t'(wdata_i[CFG_W-1:0]);
      else if (in_vec) vec_q[sel_idx] <= wdata_i;
      else begin
        case (addr_i)
          A_EN_SET:  en_q  <= en_q | wdata_i[NUM_SRC-1:0];
          A_EN_CLR:  en_q  <= en_q & ~wdata_i[NUM_SRC-1:0];
          A_FRC_SET: frc_q <= frc_q | (wdata_i[NUM_SRC-1:0] & NORM_MASK);
          A_FRC_CLR: frc_q <= frc_q & ~wdata_i[NUM_SRC-1:0];
          A_CTRL: begin
            gmask_q <= wdata_i[0];
            prot_q  <= wdata_i[1];
          end
          A_SPUR:    spur_q <= wdata_i;
          default: ;
        endcase
      end
    end
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    vnic_src_cell u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .src_i  (src_i[g]),
      .edge_i (cfg_q[g].edge_md),
      .inv_i  (cfg_q[g].inv),
      .clr_i  (clr[g]),
      .pend_o (pend[g])
    );
    assign prio_flat[g*PRIO_W +: PRIO_W] = cfg_q[g].prio;
  end

  assign en_pend = pend & en_q;
  assign cand    = en_pend & ~frc_q & NORM_MASK;

  vnic_arbiter #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_arb (
    .cand_i  (cand),
    .prio_i  (prio_flat),
    .valid_o (win_vld),
    .idx_o   (win_idx),
    .prio_o  (win_prio)
  );

  vnic_prio_stack #(.DEPTH(DEPTH), .PRIO_W(PRIO_W), .CNT_W(CNT_W)) u_stk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (push),
    .pop_i  (pop),
    .prio_i (win_prio),
    .top_o  (top_prio),
    .cnt_o  (stk_cnt)
  );

  assign eligible = win_vld && (stk_cnt == '0 || win_prio > top_prio);
  assign hit_ivec = addr_i == A_IVEC;
  // protect mode moves the acknowledge side effect from read to write
  assign push     = hit_ivec && (prot_q ? wr_en_i : rd_en_i) && eligible;
  assign pop      = wr_en_i && addr_i == A_EOI;

  always_comb begin
    clr = '0;
    if (push) clr[win_idx] = 1'b1;
    if (rd_en_i && addr_i == A_FVEC && !prot_q) clr[0] = 1'b1;
    if (wr_en_i && addr_i == A_ECLR) clr = clr | wdata_i[NUM_SRC-1:0];
  end

  assign irq_o  = !gmask_q && eligible;
  assign fiq_o  = !gmask_q && (en_pend[0] || |(en_pend & frc_q & NORM_MASK));
  assign wake_o = |en_pend;

  always_comb begin
    rdata_o = '0;
    if (in_cfg)      rdata_o = DATA_W'(cfg_q[sel_idx]);
    else if (in_vec) rdata_o = vec_q[sel_idx];
    else begin
      case (addr_i)
        A_IVEC:    rdata_o = eligible ? vec_q[win_idx] : spur_q;
        A_FVEC:    rdata_o = vec_q[0];
        A_EN_SET:  rdata_o = DATA_W'(en_q);
        A_FRC_SET: rdata_o = DATA_W'(frc_q);
        A_CTRL:    rdata_o = DATA_W'({prot_q, gmask_q});
        A_SPUR:    rdata_o = spur_q;
        A_PEND:    rdata_o = DATA_W'(pend);
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/vnic_checker.sv
module vnic_checker #(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned DEPTH   = 8,
  parameter int unsigned CNT_W   = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               irq_i,
  input logic               fiq_i,
  input logic               wake_i,
  input logic [NUM_SRC-1:0] en_i,
  input logic [NUM_SRC-1:0] pend_i,
  input logic               gmask_i,
  input logic               prot_i,
  input logic               rd_en_i,
  input logic               wr_en_i,
  input logic               hit_ivec_i,
  input logic               push_i,
  input logic               pop_i,
  input logic [CNT_W-1:0]   cnt_i
);
  AST_DISABLED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i == '0) |-> (!irq_i && !fiq_i && !wake_i)); // R4
  AST_GMASK_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gmask_i |-> (!irq_i && !fiq_i)); // R12
  AST_IRQ_NEEDS_WAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> wake_i); // R12
  AST_FIQ_LINE0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i[0] && pend_i[0] && !gmask_i) |-> fiq_i); // R10
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> (cnt_i < CNT_W'(DEPTH))); // R7
  AST_PUSH_GROWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> (cnt_i == $past(cnt_i) + 1'b1)); // R6
  AST_EOI_POPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && cnt_i != '0) |=> (cnt_i == $past(cnt_i) - 1'b1)); // R8
  AST_PROTECT_PURE_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prot_i && rd_en_i && !wr_en_i && hit_ivec_i) |=> $stable(cnt_i)); // R13
endmodule

bind vnic_top vnic_checker #(.NUM_SRC(NUM_SRC), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .irq_i      (irq_o),
  .fiq_i      (fiq_o),
  .wake_i     (wake_o),
  .en_i       (en_q),
  .pend_i     (pend),
  .gmask_i    (gmask_q),
  .prot_i     (prot_q),
  .rd_en_i    (rd_en_i),
  .wr_en_i    (wr_en_i),
  .hit_ivec_i (hit_ivec),
  .push_i     (push),
  .pop_i      (pop),
  .cnt_i      (stk_cnt)
);

// File: tb/vnic_top_test.sv
module vnic_top_test;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned N  = 32;
  localparam int unsigned AW = 7;
  localparam logic [AW-1:0] A_IVEC = 7'h40, A_FVEC = 7'h41, A_EN_SET = 7'h42,
    A_EN_CLR = 7'h43, A_FRC_SET = 7'h44, A_FRC_CLR = 7'h45, A_EOI = 7'h46,
    A_CTRL = 7'h47, A_SPUR = 7'h48, A_PEND = 7'h49, A_ECLR = 7'h4A;
  localparam logic [31:0] SPUR = 32'hDEAD_0000;

  // lines configured level-high, priority = line % 8, vector = 0x1000 + line
  localparam int unsigned NT = 8;
  localparam logic [31:0] TBL_SRC [NT] = '{32'h0000_0000, 32'h0000_0002, 32'h0000_8006,
    32'h0000_8080, 32'h0001_0004, 32'h8000_0000, 32'h0000_0001, 32'h0300_0000};
  localparam logic [31:0] TBL_VEC [NT] = '{SPUR, 32'h1001, 32'h100F,
    32'h1007, 32'h1002, 32'h101F, SPUR, 32'h1019};
  localparam logic [NT-1:0] TBL_IRQ = 8'b1011_1110;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  src = '0;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0, rdata, rv;
  logic          irq, fiq, wake;
  int            checks = 0, fails = 0;
  bit            done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vnic_top uut (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .fiq_o(fiq), .wake_o(wake)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0; #1;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a; #1 d = rdata;
    @(negedge clk); rd_en = 1'b0; #1;
  endtask

  task automatic drive(logic [N-1:0] v);
    @(negedge clk); src = v; #1;
  endtask

  task automatic pulse(int b);
    @(negedge clk); src[b] = 1'b1;
    @(negedge clk); src[b] = 1'b0;
    @(negedge clk); #1;
  endtask

  function automatic logic [31:0] cfgv(bit inv, bit edg, int p);
    return {27'd0, inv, edg, p[2:0]};
  endfunction

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1; #1;
    // R1 reset state
    check("R1 irq", irq, 0); check("R1 fiq", fiq, 0); check("R1 wake", wake, 0);
    rd(A_EN_SET, rv);  check("R1 enable", rv, 0);
    rd(A_FRC_SET, rv); check("R1 force", rv, 0);
    rd(A_CTRL, rv);    check("R1 ctrl", rv, 0);
    // R4 disabled line has no effect
    drive(32'h4);
    check("R4 irq disabled", irq, 0); check("R4 wake disabled", wake, 0);
    drive('0);
    for (int i = 0; i < N; i++) begin
      wr(AW'(i), cfgv(0, 0, i % 8));
      wr(AW'(N + i), 32'h1000 + i);
    end
    wr(A_SPUR, SPUR);
    wr(A_EN_SET, 32'hFFFF_FFFF);
    rd(A_EN_SET, rv); check("R4 enable readback", rv, 32'hFFFF_FFFF);

    // R5/R9/R2 arbitration table, protect mode keeps reads pure
    wr(A_CTRL, 32'h2);
    for (int k = 0; k < NT; k++) begin
      drive(TBL_SRC[k]);
      check("R5 table irq", irq, TBL_IRQ[k]);
      rd(A_IVEC, rv); check("R5 table vector", rv, TBL_VEC[k]);
    end
    drive('0);
    wr(A_CTRL, 32'h0);

    // R3 rising edge latch
    wr(AW'(5), cfgv(0, 1, 5));
    pulse(5);
    rd(A_PEND, rv); check("R3 rising latch", rv[5], 1);
    check("R3 irq after edge", irq, 1);
    // R6 acknowledge stacks and clears
    rd(A_IVEC, rv); check("R6 vector", rv, 32'h1005);
    check("R6 irq dropped", irq, 0);
    rd(A_PEND, rv); check("R6 latch cleared", rv[5], 0);
    // R7 nesting
    drive(32'h4);      check("R7 lower blocked", irq, 0);
    drive(32'h4004);   check("R7 higher preempts", irq, 1);
    rd(A_IVEC, rv);    check("R7 nested vector", rv, 32'h100E);
    check("R7 equal blocked", irq, 0);
    // R8 end of service
    wr(A_EOI, 0);      check("R8 pop reopens", irq, 1);
    drive(32'h4);      check("R8 level 5 still blocks", irq, 0);
    wr(A_EOI, 0);      check("R8 empty stack", irq, 1);
    rd(A_IVEC, rv);    check("R8 vector after pop", rv, 32'h1002);
    drive('0);
    wr(A_EOI, 0);      check("R8 idle", irq, 0);
    // R9 spurious
    rd(A_IVEC, rv);    check("R9 spurious vector", rv, SPUR);
    drive(32'h2);      check("R9 stack untouched", irq, 1);
    drive('0);

    // R2 low level
    wr(AW'(3), cfgv(1, 0, 3));
    check("R2 low level pending", irq, 1);
    drive(32'h8);      check("R2 low level released", irq, 0);
    wr(AW'(3), cfgv(0, 0, 3));
    drive('0);
    // R3 falling edge
    wr(AW'(6), cfgv(1, 1, 6));
    drive(32'h40);
    rd(A_PEND, rv);    check("R3 high level no latch", rv[6], 0);
    drive('0);
    rd(A_PEND, rv);    check("R3 falling latch", rv[6], 1);
    wr(A_ECLR, 32'h40);
    rd(A_PEND, rv);    check("R3 latch cleared by write", rv[6], 0);
    wr(AW'(6), cfgv(0, 0, 6));

    // R10 fast line
    drive(32'h1);
    check("R10 fiq level", fiq, 1); check("R10 no irq", irq, 0);
    rd(A_FVEC, rv);    check("R10 fast vector", rv, 32'h1000);
    drive('0);         check("R10 fiq released", fiq, 0);
    wr(AW'(0), cfgv(0, 1, 0));
    pulse(0);          check("R10 fiq edge", fiq, 1);
    rd(A_FVEC, rv);    check("R10 fast ack clears", fiq, 0);

    // R11 forcing
    wr(A_FRC_SET, 32'h200);
    wr(AW'(9), cfgv(0, 1, 1));
    pulse(9);
    check("R11 forced fiq", fiq, 1); check("R11 forced no irq", irq, 0);
    rd(A_IVEC, rv);    check("R11 excluded from vector", rv, SPUR);
    rd(A_FVEC, rv);
    check("R11 not auto cleared", fiq, 1);
    wr(A_ECLR, 32'h200);
    check("R11 cleared by write", fiq, 0);
    wr(A_FRC_CLR, 32'h200);
    rd(A_FRC_SET, rv); check("R11 force cleared", rv, 0);

    // R12 global mask
    wr(A_CTRL, 32'h1);
    drive(32'h4);
    check("R12 irq masked", irq, 0); check("R12 wake", wake, 1);
    wr(A_CTRL, 32'h0); check("R12 unmasked", irq, 1);
    drive('0);

    // R13 protect mode
    wr(A_CTRL, 32'h2);
    pulse(5);
    rd(A_IVEC, rv);    check("R13 vector", rv, 32'h1005);
    check("R13 read no stack", irq, 1);
    rd(A_PEND, rv);    check("R13 read no clear", rv[5], 1);
    wr(A_IVEC, 0);
    check("R13 write stacks", irq, 0);
    rd(A_PEND, rv);    check("R13 write clears", rv[5], 0);
    drive(32'h4);      check("R13 level 5 blocks", irq, 0);
    wr(A_EOI, 0);      check("R13 pop", irq, 1);
    drive('0);

    done = 1'b1;
    report();
    $finish;
  end
endmodule